// File: doc/BRIEF.md
# Circular Return Address Stack

This block keeps the return addresses of a small processor core. Each call instruction and each interrupt entry stores the current 13-bit address on the stack. Each of the three return-type instructions removes one address. The most recently stored address is always driven on a registered output bus, so the program counter logic can take it in the same cycle that it issues a pop.

The stack has eight slots. Its pointer is internal and cannot be read or loaded from outside. The storage is used as a ring. Once eight addresses are held, each further store overwrites the oldest one. A pop with nothing left moves the pointer backwards around the ring and exposes whatever that slot still holds. No overflow or underflow indication exists. The instruction decoder and the program counter live outside the block.

Top module: `ret_addr_stack`

## Requirements
- R1: While `rst` is high at a rising clock edge, the internal pointer returns to slot 0 and `top_o` becomes 0 at that edge. Slot contents are not cleared.
- R2: A push alone (`push_i`=1, `pop_i`=0) shows `push_addr_i` on `top_o` from the next clock edge.
- R3: A pop alone (`push_i`=0, `pop_i`=1) moves the pointer back by one. From the next edge, `top_o` shows the address stored just before the one removed.
- R4: Up to eight pushes followed by pops return the addresses in reverse order of pushing.
- R5: Pushes wrap around eight slots. The ninth push overwrites the first address stored and the tenth overwrites the second. After nine pushes, eight pops show the pushed values 8 down to 2, then value 9 again.
- R6: A pop with no stored address still moves the pointer back, wrapping from slot 0 to slot 7. `top_o` then shows the old contents of the slot below the new pointer position.
- R7: A push and a pop in the same cycle replace the top address with `push_addr_i` and leave the pointer unchanged. The entries below are not disturbed.
- R8: In a cycle with neither push nor pop, `top_o` and the pointer hold their values.
- R9: All 13 address bits are stored and returned unchanged, including the values 0x1FFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Store `push_addr_i` (call or interrupt entry) |
| pop_i | input | 1 | Remove the top address (return-type instruction) |
| push_addr_i | input | 13 | Return address to store |
| top_o | output | 13 | Registered copy of the current top address |

## Verification
The hardest case to reach from the ports is a stack that has wrapped. In that state the ring slots hold addresses from two different generations of pushes, and the pointer has passed slot 0 in both directions. The only view of the pointer is through `top_o`.

The stimulus first fills all eight slots with distinct addresses, so that no slot is left undefined. It then pops past empty to force the backward wrap. Later it pushes nine and more addresses to force the forward overwrite. A reference ring in the bench predicts every top value through these sequences, and also through combined push-and-pop cycles placed in the middle.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } ras_op_e;

  function automatic ras_op_e op_of(input logic push, input logic pop);
    return ras_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  ras_op_e       op,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] ptr_m1,
  output logic [PW-1:0] ptr_m2
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] step_up(input logic [PW-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [PW-1:0] step_dn(input logic [PW-1:0] v);
    return (v == '0) ? LAST : v - 1'b1;
  endfunction

  assign ptr_m1 = step_dn(ptr_q);
  assign ptr_m2 = step_dn(ptr_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH: ptr_q <= step_up(ptr_q);
        OP_POP:  ptr_q <= ptr_m1;
        default: ptr_q <= ptr_q;
      endcase
    end
  end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 13,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ras_topreg.sv
module ras_topreg
  import ras_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  ras_op_e       op,
  input  logic [AW-1:0] push_addr,
  input  logic [AW-1:0] below,
  output logic [AW-1:0] top_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH, OP_SWAP: top_q <= push_addr;
        OP_POP:           top_q <= below;
        default:          top_q <= top_q;
      endcase
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ras_op_e       op;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_m1;
  logic [PW-1:0] ptr_m2;
  logic          wr_en;
  logic [PW-1:0] wr_slot;
  logic [AW-1:0] below_top;

  assign op      = op_of(push_i, pop_i);
  assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_slot = (op == OP_SWAP) ? ptr_m1 : ptr_q;

  ras_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .ptr_q  (ptr_q),
    .ptr_m1 (ptr_m1),
    .ptr_m2 (ptr_m2)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_slot),
    .wdata (push_addr_i),
    .raddr (ptr_m2),
    .rdata (below_top)
  );

  ras_topreg #(.AW(AW)) u_top (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .push_addr (push_addr_i),
    .below     (below_top),
    .top_q     (top_o)
  );

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 13,
  parameter int PW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] top_o,
  input logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ptr == '0 && top_o == '0));

  assert_push_shows_R2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> top_o == $past(push_addr_i));

  assert_push_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

  assert_pop_back_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> ptr == (($past(ptr) == '0) ? LAST : $past(ptr) - 1'b1));

  assert_pop_prev_top_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && ptr == '0) |=> ptr == LAST);

  assert_swap_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> ($stable(ptr) && top_o == $past(push_addr_i)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> ($stable(ptr) && $stable(top_o)));

endmodule

bind ret_addr_stack ras_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_addr_i (push_addr_i),
  .top_o       (top_o),
  .ptr         (ptr_q)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;

  localparam int DEPTH = 8;
  localparam int AW    = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] top_o;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] ring [DEPTH];
  int            mptr = 0;
  logic [AW-1:0] mtop = '0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  ret_addr_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .top_o       (top_o)
  );

  task automatic step(input logic p, input logic q, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    push_i = p;
    pop_i = q;
    push_addr_i = a;
    if (p && q) begin
      ring[(mptr + DEPTH - 1) % DEPTH] = a;
      mtop = a;
    end else if (p) begin
      ring[mptr] = a;
      mptr = (mptr + 1) % DEPTH;
      mtop = a;
    end else if (q) begin
      mptr = (mptr + DEPTH - 1) % DEPTH;
      mtop = ring[(mptr + DEPTH - 1) % DEPTH];
    end
    exp_q.push_back(mtop);
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (top_o !== e) begin
        failures++;
        $display("FAIL %s top_o actual=%h expected=%h", t, top_o, e);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (top_o !== '0) begin
      failures++;
      $display("FAIL R1 reset top_o actual=%h expected=%h", top_o, 13'h0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2 and R4: fill all eight slots
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 13'(16'h0100 + i * 16'h0111), "R2");
    // R3 and R4: reverse order
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0, "R4");
    // R6: pops past empty wrap backwards
    step(1'b0, 1'b1, '0, "R6");
    step(1'b0, 1'b1, '0, "R6");
    // R8: idle holds
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 13'h1ABC, "R8");
    // R9: extreme values
    step(1'b1, 1'b0, 13'h1FFF, "R9");
    step(1'b1, 1'b0, 13'h0000, "R9");
    step(1'b0, 1'b1, '0, "R9");
    // R7: combined push and pop
    step(1'b1, 1'b0, 13'h0AAA, "R7");
    step(1'b1, 1'b1, 13'h1555, "R7");
    step(1'b0, 1'b1, '0, "R7");
    step(1'b0, 1'b1, '0, "R3");

    // R5: reset then nine pushes and nine pops
    @(negedge clk);
    rst = 1'b1;
    push_i = 1'b0;
    pop_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mptr = 0;
    mtop = '0;
    for (int i = 1; i <= 9; i++) step(1'b1, 1'b0, 13'(16'h0F00 + i), "R5");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, '0, "R5");
    for (int i = 1; i <= 11; i++) step(1'b1, 1'b0, 13'(16'h1200 + i * 3), "R5");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, '0, "R5");
    step(1'b0, 1'b0, '0, "R8");

    @(negedge clk);
    push_i = 1'b0;
    pop_i = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    summary();
  end

endmodule